// File: doc/BRIEF.md
# Reset and NMI Vector Fetch Sequencer

This block sits between a small 8-bit processor core and a memory bus with a 16-bit address and 8-bit data. It runs the two entry sequences in which the core does not fetch for itself: start-up and the non-maskable interrupt. While the core is held in reset, the block reads a two-byte start address from a fixed pair of locations. The high byte comes first from 16'hFFFE and goes into a program-counter high register. The low byte comes from 16'hFFFF and goes into a low register. The core is released when the reset request falls.

A rising edge on the interrupt request is synchronised and accepted whenever the core is running, with no mask. The block first asks the core to save its context and waits for the acknowledge. It then reads the handler address, high byte from 16'hFFFC and low byte from 16'hFFFD, and redirects the core through a one-cycle load pulse. During its own fetches the block owns the bus: it drives the address, keeps the read/write strobe at read, and keeps the data drivers off. At all other times it passes the core's address and strobe through. The data-bus output enable is gated by an external output-disable input.

Top module: `vector_fetch_seq`

## Requirements
- R1: After the block's reset is released, and after any later reset request, the bus shows address 16'hFFFE and then 16'hFFFF in the next cycle, with core_hold_o high in both cycles.
- R2: The completed program counter on pc_o is {byte read at 16'hFFFE, byte read at 16'hFFFF}. The read data is taken one cycle after its address is presented.
- R3: core_hold_o stays high and pc_load_o stays low for as long as cpu_reset_i (active high) is held. After cpu_reset_i falls, pc_load_o pulses in the same cycle that core_hold_o falls.
- R4: A rising edge on nmi_i while the core runs raises ctx_req_o. ctx_req_o stays high until ctx_ack_i is seen. During this wait core_hold_o is low and the core keeps the bus.
- R5: After the acknowledge, the bus shows 16'hFFFC and then 16'hFFFD with core_hold_o high. pc_o then becomes {byte at 16'hFFFC, byte at 16'hFFFD} with a one-cycle pc_load_o pulse, and core_hold_o falls.
- R6: Only a rising edge of nmi_i starts a sequence. A level held high does not retrigger. An edge that arrives while a sequence is in progress is dropped.
- R7: A reset request during an interrupt sequence abandons it: ctx_req_o drops, and the reset vector is fetched and delivered instead.
- R8: While core_hold_o is high, bus_rw_o is high (read) and data_oe_o is low. Otherwise bus_addr_o equals core_addr_i and bus_rw_o equals core_rw_i (low = write).
- R9: data_oe_o is high only when bus_rw_o is low and od_i is low.
- R10: pc_load_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cpu_reset_i | input | 1 | Active-high reset request, asynchronous |
| nmi_i | input | 1 | Active-high non-maskable interrupt request, asynchronous |
| core_addr_i | input | 16 | Core bus address |
| core_rw_i | input | 1 | Core read/write strobe, low = write |
| od_i | input | 1 | Output disable; high blocks the data drivers |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| ctx_ack_i | input | 1 | Core finished saving context |
| bus_addr_o | output | 16 | Address to memory |
| bus_rw_o | output | 1 | Read/write strobe to memory, low = write |
| data_oe_o | output | 1 | Data bus output enable |
| core_hold_o | output | 1 | Core stalled while the block owns the bus |
| ctx_req_o | output | 1 | Request to the core to save context |
| pc_o | output | 16 | Fetched program counter {high, low} |
| pc_load_o | output | 1 | One-cycle pulse: load pc_o into the core |

## Verification
The assertions check the following on every cycle: the bus rules while the block holds the core, the output-disable gating, the single-cycle load pulse, the load pulse lining up with the release of the core, and the step from the first vector address to the second. Only the bench scenarios can show the rest. Those are the actual byte order in pc_o, the core being held for as long as the reset request lasts, the acknowledge handshake, a held interrupt level or an edge during a sequence being ignored, and a reset pre-empting an interrupt sequence already under way.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R_HI,
    ST_R_LO,
    ST_R_END,
    ST_R_WAIT,
    ST_N_SAVE,
    ST_N_HI,
    ST_N_LO,
    ST_N_END
  } seq_state_e;
endpackage

// File: rtl/vseq_sync.sv
module vseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vseq_fsm.sv
module vseq_fsm
  import vseq_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] RST_VEC = 16'hFFFE,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'hFFFC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rst_lvl_i,
  input  logic                nmi_rise_i,
  input  logic                ctx_ack_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                own_bus_o,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  output logic                ctx_req_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic                pc_load_o
);
  localparam logic [ADDR_W-1:0] RST_VEC_LO = RST_VEC + 1'b1;
  localparam logic [ADDR_W-1:0] NMI_VEC_LO = NMI_VEC + 1'b1;

  seq_state_e          state_q, state_d;
  logic [DATA_W-1:0]   ph_q, pl_q;
  logic                load_q;
  logic                in_rst_seq;

  assign in_rst_seq = (state_q == ST_R_HI) || (state_q == ST_R_LO) ||
                      (state_q == ST_R_END) || (state_q == ST_R_WAIT);

  always_comb begin
    state_d = state_q;
    if (rst_lvl_i && !in_rst_seq) begin
      state_d = ST_R_HI;  // reset pre-empts everything
    end else begin
      unique case (state_q)
        ST_IDLE:   if (nmi_rise_i) state_d = ST_N_SAVE;
        ST_R_HI:   state_d = ST_R_LO;
        ST_R_LO:   state_d = ST_R_END;
        ST_R_END:  state_d = ST_R_WAIT;
        ST_R_WAIT: if (!rst_lvl_i) state_d = ST_IDLE;
        ST_N_SAVE: if (ctx_ack_i) state_d = ST_N_HI;
        ST_N_HI:   state_d = ST_N_LO;
        ST_N_LO:   state_d = ST_N_END;
        ST_N_END:  state_d = ST_IDLE;
        default:   state_d = ST_R_HI;
      endcase
    end
  end

  always_comb begin
    own_bus_o    = 1'b1;
    fetch_addr_o = RST_VEC_LO;
    unique case (state_q)
      ST_IDLE, ST_N_SAVE: own_bus_o = 1'b0;
      ST_R_HI:            fetch_addr_o = RST_VEC;
      ST_N_HI:            fetch_addr_o = NMI_VEC;
      ST_N_LO, ST_N_END:  fetch_addr_o = NMI_VEC_LO;
      default:            fetch_addr_o = RST_VEC_LO;
    endcase
  end

  assign ctx_req_o = (state_q == ST_N_SAVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_R_HI;
      ph_q    <= '0;
      pl_q    <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= 1'b0;
      if (state_q == ST_R_LO || (state_q == ST_N_LO && !rst_lvl_i))
        ph_q <= rdata_i;
      if (state_q == ST_R_END || (state_q == ST_N_END && !rst_lvl_i))
        pl_q <= rdata_i;
      if (((state_q == ST_N_END) || (state_q == ST_R_WAIT)) && !rst_lvl_i)
        load_q <= 1'b1;
    end
  end

  assign pc_o      = {ph_q, pl_q};
  assign pc_load_o = load_q;
endmodule

// File: rtl/vseq_bus_mux.sv
module vseq_bus_mux #(
  parameter int ADDR_W = 16
) (
  input  logic              own_bus_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic              core_rw_i,
  input  logic              od_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rw_o,
  output logic              data_oe_o
);
  assign bus_addr_o = own_bus_i ? fetch_addr_i : core_addr_i;
  assign bus_rw_o   = own_bus_i | core_rw_i;
  assign data_oe_o  = ~bus_rw_o & ~od_i;
endmodule

// File: rtl/vector_fetch_seq.sv
module vector_fetch_seq #(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RST_VEC   = 16'hFFFE,
  parameter logic [ADDR_W-1:0] NMI_VEC   = 16'hFFFC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_reset_i,
  input  logic                nmi_i,
  input  logic [ADDR_W-1:0]   core_addr_i,
  input  logic                core_rw_i,
  input  logic                od_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                ctx_ack_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                bus_rw_o,
  output logic                data_oe_o,
  output logic                core_hold_o,
  output logic                ctx_req_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic                pc_load_o
);
  logic rst_lvl, rst_rise_unused, nmi_lvl_unused, nmi_rise;
  logic own_bus;
  logic [ADDR_W-1:0] fetch_addr;

  vseq_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i, .rst_ni, .async_i(cpu_reset_i),
    .level_o(rst_lvl), .rise_o(rst_rise_unused)
  );

  vseq_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
    .clk_i, .rst_ni, .async_i(nmi_i),
    .level_o(nmi_lvl_unused), .rise_o(nmi_rise)
  );

  vseq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_VEC(RST_VEC), .NMI_VEC(NMI_VEC)
  ) u_fsm (
    .clk_i, .rst_ni,
    .rst_lvl_i(rst_lvl), .nmi_rise_i(nmi_rise), .ctx_ack_i,
    .rdata_i(mem_rdata_i),
    .own_bus_o(own_bus), .fetch_addr_o(fetch_addr),
    .ctx_req_o, .pc_o, .pc_load_o
  );

  vseq_bus_mux #(.ADDR_W(ADDR_W)) u_mux (
    .own_bus_i(own_bus), .fetch_addr_i(fetch_addr),
    .core_addr_i, .core_rw_i, .od_i,
    .bus_addr_o, .bus_rw_o, .data_oe_o
  );

  assign core_hold_o = own_bus;
endmodule

// File: rtl/vector_fetch_seq_chk.sv
module vector_fetch_seq_chk #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] RST_VEC = 16'hFFFE,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'hFFFC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_rw_o,
  input logic              data_oe_o,
  input logic              od_i,
  input logic              core_hold_o,
  input logic              ctx_req_o,
  input logic              pc_load_o
);
  localparam logic [ADDR_W-1:0] RST_LO = RST_VEC + 1'b1;
  localparam logic [ADDR_W-1:0] NMI_LO = NMI_VEC + 1'b1;

  // R1
  rst_vec_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_hold_o && bus_addr_o == RST_VEC) |=> (core_hold_o && bus_addr_o == RST_LO));

  // R5
  nmi_vec_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_hold_o && bus_addr_o == NMI_VEC) |=>
      (core_hold_o && (bus_addr_o == NMI_LO || bus_addr_o == RST_VEC)));

  // R3
  release_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_hold_o) |-> pc_load_o);

  // R5
  load_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> !core_hold_o);

  // R4
  ctx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctx_req_o) |-> core_hold_o);

  // R8
  hold_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_hold_o |-> (bus_rw_o && !data_oe_o));

  // R9
  od_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_i || bus_rw_o) |-> !data_oe_o);

  // R10
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);
endmodule

bind vector_fetch_seq vector_fetch_seq_chk #(
  .ADDR_W(ADDR_W), .RST_VEC(RST_VEC), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_o(bus_addr_o), .bus_rw_o(bus_rw_o),
  .data_oe_o(data_oe_o), .od_i(od_i), .core_hold_o(core_hold_o),
  .ctx_req_o(ctx_req_o), .pc_load_o(pc_load_o)
);

// File: tb/vector_fetch_seq_bench.sv
module vector_fetch_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_reset_i = 1'b1;
  logic        nmi_i = 1'b0;
  logic [15:0] core_addr_i = 16'h1000;
  logic        core_rw_i = 1'b1;
  logic        od_i = 1'b0;
  logic [7:0]  mem_rdata_i = 8'h00;
  logic        ctx_ack_i = 1'b0;
  logic [15:0] bus_addr_o;
  logic        bus_rw_o, data_oe_o, core_hold_o, ctx_req_o, pc_load_o;
  logic [15:0] pc_o;

  int total = 0;
  int bad = 0;
  logic [15:0] rst_vec_val = 16'h1234;
  logic [15:0] nmi_vec_val = 16'hA55A;

  always #2 clk_i = ~clk_i;

  vector_fetch_seq u_vector_fetch_seq (.*);

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    case (a)
      16'hFFFE: mem_byte = rst_vec_val[15:8];
      16'hFFFF: mem_byte = rst_vec_val[7:0];
      16'hFFFC: mem_byte = nmi_vec_val[15:8];
      16'hFFFD: mem_byte = nmi_vec_val[7:0];
      default:  mem_byte = a[15:8] ^ a[7:0];
    endcase
  endfunction

  always @(posedge clk_i) mem_rdata_i <= mem_byte(bus_addr_o);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_addr(input logic [15:0] a, input string tag);
    int n = 0;
    while (!(core_hold_o && bus_addr_o == a) && n < 40) begin
      @(negedge clk_i); n++;
    end
    chk(n < 40, tag, bus_addr_o, a);
  endtask

  task automatic wait_load(input logic [15:0] exp, input string tag);
    int n = 0;
    while (!pc_load_o && n < 40) begin
      @(negedge clk_i); n++;
    end
    chk(pc_load_o, {tag, " load pulse"}, pc_load_o, 1);
    chk(pc_o == exp, {tag, " pc value"}, pc_o, exp);
    chk(!core_hold_o, {tag, " hold released with pulse"}, core_hold_o, 0);
    @(negedge clk_i);
    // R10
    chk(!pc_load_o, "R10 pulse one cycle", pc_load_o, 0);
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!ctx_req_o && n < 20) begin
      @(negedge clk_i); n++;
    end
    chk(ctx_req_o, tag, ctx_req_o, 1);
  endtask

  task automatic ack_once;
    ctx_ack_i = 1'b1;
    @(negedge clk_i);
    ctx_ack_i = 1'b0;
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    chk(pc_o == 16'h0 && !pc_load_o && !ctx_req_o, "R3 reset state", {pc_o, 7'b0, pc_load_o, 7'b0, ctx_req_o}, 0);
  endtask

  task automatic t_boot;
    @(negedge clk_i) rst_ni = 1'b1;
    wait_addr(16'hFFFE, "R1 first reset address");
    @(negedge clk_i);
    chk(core_hold_o && bus_addr_o == 16'hFFFF, "R1 second reset address", bus_addr_o, 16'hFFFF);
    chk(bus_rw_o && !data_oe_o, "R8 fetch is a read", {bus_rw_o, data_oe_o}, 2'b10);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (!core_hold_o || pc_load_o) chk(1'b0, "R3 held while reset high", {core_hold_o, pc_load_o}, 2'b10);
    end
    chk(core_hold_o, "R3 still held", core_hold_o, 1);
    cpu_reset_i = 1'b0;
    wait_load(16'h1234, "R2 R3 boot");
  endtask

  task automatic t_passthru;
    core_addr_i = 16'h1357; core_rw_i = 1'b0; od_i = 1'b0;
    @(negedge clk_i);
    chk(bus_addr_o == 16'h1357 && !bus_rw_o, "R8 core passthrough", {bus_addr_o, 7'b0, bus_rw_o}, {16'h1357, 8'h0});
    chk(data_oe_o, "R9 write enables drivers", data_oe_o, 1);
    od_i = 1'b1;
    @(negedge clk_i);
    chk(!data_oe_o, "R9 od blocks drivers", data_oe_o, 0);
    od_i = 1'b0; core_rw_i = 1'b1;
    @(negedge clk_i);
    chk(!data_oe_o && bus_rw_o, "R9 read keeps drivers off", data_oe_o, 0);
  endtask

  task automatic t_nmi;
    core_addr_i = 16'h2468;
    nmi_i = 1'b1;
    wait_req("R4 request raised");
    chk(!core_hold_o && bus_addr_o == 16'h2468, "R4 core keeps bus while saving", bus_addr_o, 16'h2468);
    repeat (5) @(negedge clk_i);
    chk(ctx_req_o, "R4 request held until ack", ctx_req_o, 1);
    core_rw_i = 1'b0;
    ack_once;
    wait_addr(16'hFFFC, "R5 first nmi address");
    chk(!ctx_req_o, "R4 request drops after ack", ctx_req_o, 0);
    chk(bus_rw_o && !data_oe_o, "R8 core write masked during fetch", {bus_rw_o, data_oe_o}, 2'b10);
    @(negedge clk_i);
    chk(core_hold_o && bus_addr_o == 16'hFFFD, "R5 second nmi address", bus_addr_o, 16'hFFFD);
    core_rw_i = 1'b1;
    wait_load(16'hA55A, "R5 nmi");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (ctx_req_o || core_hold_o) chk(1'b0, "R6 held level no retrigger", ctx_req_o, 0);
    end
    chk(!ctx_req_o, "R6 level ignored", ctx_req_o, 0);
    nmi_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_nmi_edge_during;
    nmi_vec_val = 16'h0F0E;
    nmi_i = 1'b1;
    wait_req("R6 request for first edge");
    nmi_i = 1'b0;
    repeat (4) @(negedge clk_i);
    nmi_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ack_once;
    wait_load(16'h0F0E, "R6 first edge served");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (ctx_req_o) chk(1'b0, "R6 edge during sequence dropped", ctx_req_o, 0);
    end
    chk(!ctx_req_o && !core_hold_o, "R6 no second sequence", ctx_req_o, 0);
    nmi_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_nmi_reset;
    rst_vec_val = 16'hBEEF;
    nmi_i = 1'b1;
    wait_req("R7 request before reset");
    cpu_reset_i = 1'b1;
    wait_addr(16'hFFFE, "R7 reset vector fetched");
    chk(!ctx_req_o, "R7 request abandoned", ctx_req_o, 0);
    repeat (6) @(negedge clk_i);
    chk(core_hold_o && !pc_load_o, "R7 held during reset", {core_hold_o, pc_load_o}, 2'b10);
    cpu_reset_i = 1'b0;
    wait_load(16'hBEEF, "R7 reset vector delivered");
    nmi_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_state;
    t_boot;
    t_passthru;
    t_nmi;
    t_nmi_edge_during;
    t_nmi_reset;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule